// File: doc/BRIEF.md
# Paged Write Address Controller

This block sits behind a two-wire serial slave front end that has already turned bus traffic into byte-level events. It owns the write side of an 80-byte nonvolatile array laid out as five 16-byte pages at byte addresses 80h to CFh. After an address byte, each received data byte goes into a one-page staging buffer at the current pointer. The low four pointer bits then advance and wrap inside the page, while the page bits never change. A clean STOP commits the staged bytes to the array in one step and starts an internal write cycle, during which the block reports busy and ignores all traffic.

The commit is gated by a volatile write-enable latch, an active-low write-protect pin and a page rule. The lowest page, 80h to 8Fh, holds control bytes and takes only single-byte writes. The latch itself sits at address 86h, bit 7. A single-byte write there updates the latch at once, and needs neither the latch nor the protect pin. A byte-level read port lets the front end fetch array contents and the latch.

Top module: `page_write_ctrl`

## Requirements
- R1: After reset, busy is low, the pointer reads 00h, every array byte reads 00h and the latch is clear (address 86h reads 00h).
- R2: Each accepted data byte increments pointer bits [3:0] by one, wrapping from 15 to 0, and leaves bits [7:4] unchanged.
- R3: Twelve bytes written from address 9Bh land at 9Bh–9Fh and then 90h–96h, and the pointer then reads 97h.
- R4: When more than 16 bytes are sent in one write, a later byte replaces the earlier byte staged at the same wrapped offset, and only the last value per offset reaches the array.
- R5: A commit updates exactly the offsets that received a byte in that transaction; all other array bytes keep their values.
- R6: A committing STOP raises busy on the next cycle for exactly WRITE_CYCLES cycles; events arriving while busy have no effect on the array, the latch or the pointer.
- R7: A write of two or more bytes to 80h–8Fh is dropped entirely; a single-byte write there (other than to 86h) is committed.
- R8: With the latch clear, no array write is committed.
- R9: With the protect pin low, no array write is committed, yet a single-byte write to 86h still updates the latch.
- R10: A STOP flagged as not falling on a byte boundary (stopAligned low) commits nothing.
- R11: A START arriving before STOP discards the staged bytes; nothing from that transaction is committed.
- R12: A write whose start address lies below 80h or above CFh commits nothing and does not change the latch.
- R13: A single-byte write to 86h copies data bit 7 into the latch without starting a write cycle; reading 86h returns the latch in bit 7 and zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startEv | input | 1 | START or repeated START seen (one-cycle strobe) |
| stopEv | input | 1 | STOP seen (one-cycle strobe) |
| stopAligned | input | 1 | High when the STOP followed a complete byte and acknowledge |
| addrValid | input | 1 | Address byte of a write received |
| addrByte | input | 8 | Start byte address |
| dataValid | input | 1 | Data byte received |
| dataByte | input | 8 | Data byte value |
| wpN | input | 1 | Write protect, active low |
| rdAddr | input | 8 | Read address |
| busy | output | 1 | Internal write cycle in progress |
| ptrOut | output | 8 | Current byte address pointer |
| rdData | output | 8 | Byte at rdAddr (latch image at 86h, zero out of range) |

## Verification
The hardest case to reach is one where the wrapped pointer, the staging flags and the commit gating all meet in one transaction. An example is a write of more than 16 bytes whose commit must hold only the last byte for each offset, started while the previous write cycle is still counting. The stimulus reaches it by queueing transactions back to back, one of them landing inside the busy window, and by toggling the latch and protect pin between writes. A behavioural model with plain integer arrays follows every clock edge and is compared with the pointer and busy each cycle and with a full read-back sweep of the array after each scenario.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Strobes from the control FSM to the datapath, one cycle each.
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic clearBuf;
    logic commit;
    logic setLatch;
  } pwcStrobe_t;

  // Facts the datapath reports back for the STOP decision.
  typedef struct packed {
    logic       inRange;
    logic       ctrlPage;
    logic       latchTarget;
    logic [1:0] byteCnt;      // 0, 1, or 2 meaning "several"
    logic       weLatch;
  } pwcStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_BUSY = 2'd2
  } pwcState_t;

endpackage

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
  import pwc_pkg::*;
#(
  parameter int WRITE_CYCLES = 20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       stopAligned,
  input  logic       addrValid,
  input  logic       dataValid,
  input  logic       wpN,
  input  pwcStatus_t stat,
  output pwcStrobe_t strb,
  output logic       busy
);

  localparam int CYC_W = $clog2(WRITE_CYCLES + 1);

  pwcState_t        state, nextState;
  logic [CYC_W-1:0] cycCnt, nextCnt;
  logic             stopGood, singleByte, writeAllowed;

  // A STOP is usable when it ends a whole byte, the target is mapped
  // and at least one byte was staged.
  assign stopGood     = stopAligned && stat.inRange && (stat.byteCnt != 2'd0);
  assign singleByte   = (stat.byteCnt == 2'd1);
  assign writeAllowed = stat.weLatch && wpN && (!stat.ctrlPage || singleByte);

  always_comb begin
    strb      = '0;
    nextState = state;
    nextCnt   = cycCnt;
    unique case (state)
      ST_IDLE: begin
        if (addrValid) begin
          strb.loadAddr = 1'b1;
          nextState     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (startEv) begin
          strb.clearBuf = 1'b1;
          nextState     = ST_IDLE;
        end else if (stopEv) begin
          strb.clearBuf = 1'b1;
          nextState     = ST_IDLE;
          if (stopGood && stat.latchTarget && singleByte) begin
            strb.setLatch = 1'b1;
          end else if (stopGood && writeAllowed) begin
            strb.commit = 1'b1;
            nextState   = ST_BUSY;
            nextCnt     = CYC_W'(WRITE_CYCLES - 1);
          end
        end else if (addrValid) begin
          strb.loadAddr = 1'b1;
        end else if (dataValid) begin
          strb.storeByte = 1'b1;
        end
      end
      ST_BUSY: begin
        if (cycCnt == '0) nextState = ST_IDLE;
        else              nextCnt   = cycCnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
    end else begin
      state  <= nextState;
      cycCnt <= nextCnt;
    end
  end

  assign busy = (state == ST_BUSY);

endmodule

// File: rtl/pwc_datapath.sv
module pwc_datapath
  import pwc_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int NUM_PAGES    = 5,
  parameter int BASE_ADDR    = 'h80,
  parameter int LATCH_OFFSET = 6,
  parameter int LATCH_BIT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrByte,
  input  logic [7:0]        dataByte,
  input  pwcStrobe_t        strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output pwcStatus_t        stat,
  output logic [ADDR_W-1:0] ptrOut,
  output logic [7:0]        rdData
);

  localparam int OFF_W       = $clog2(PAGE_BYTES);
  localparam int PAGE_W      = $clog2(NUM_PAGES);
  localparam int ARRAY_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam int IDX_W       = $clog2(ARRAY_BYTES);
  localparam logic [ADDR_W-1:0] BASE       = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(ARRAY_BYTES);
  localparam logic [ADDR_W-1:0] LATCH_ADDR = ADDR_W'(BASE_ADDR + LATCH_OFFSET);

  logic [ADDR_W-1:0]     ptrQ;
  logic [OFF_W-1:0]      startOffQ;
  logic [1:0]            cntQ;
  logic                  latchQ;
  logic [7:0]            bufQ   [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validQ;
  logic [7:0]            memQ   [ARRAY_BYTES];

  logic [ADDR_W-1:0] relPtr;
  logic [PAGE_W-1:0] pageIdx;
  logic [OFF_W-1:0]  curOff;
  logic              dropBuf;

  assign relPtr  = ptrQ - BASE;
  assign pageIdx = relPtr[OFF_W +: PAGE_W];
  assign curOff  = ptrQ[OFF_W-1:0];
  assign dropBuf = strb.clearBuf || strb.loadAddr;

  // Pointer, start offset, byte count and latch.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ      <= '0;
      startOffQ <= '0;
      cntQ      <= '0;
      latchQ    <= 1'b0;
    end else begin
      if (strb.loadAddr) begin
        ptrQ      <= addrByte;
        startOffQ <= addrByte[OFF_W-1:0];
      end else if (strb.storeByte) begin
        // Page bits held, offset wraps inside the page.
        ptrQ <= {ptrQ[ADDR_W-1:OFF_W], curOff + 1'b1};
      end
      if (dropBuf)                               cntQ <= '0;
      else if (strb.storeByte && cntQ != 2'd2)   cntQ <= cntQ + 1'b1;
      if (strb.setLatch) latchQ <= bufQ[LATCH_OFFSET][LATCH_BIT];
    end
  end

  // One staging slot per page offset with its own valid flag.
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        bufQ[g]   <= '0;
      end else if (dropBuf) begin
        validQ[g] <= 1'b0;
      end else if (strb.storeByte && curOff == OFF_W'(g)) begin
        validQ[g] <= 1'b1;
        bufQ[g]   <= dataByte;
      end
    end
  end

  // Array cells: each updates from its slot when its page commits.
  for (genvar e = 0; e < ARRAY_BYTES; e++) begin : g_cell
    localparam int CELL_PAGE = e / PAGE_BYTES;
    localparam int CELL_SLOT = e % PAGE_BYTES;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memQ[e] <= '0;
      end else if (strb.commit && pageIdx == PAGE_W'(CELL_PAGE) && validQ[CELL_SLOT]) begin
        memQ[e] <= bufQ[CELL_SLOT];
      end
    end
  end

  // Read port.
  logic [ADDR_W-1:0] rdRel;
  always_comb begin
    rdData = '0;
    rdRel  = rdAddr - BASE;
    if (rdAddr == LATCH_ADDR) begin
      rdData[LATCH_BIT] = latchQ;
    end else if (rdAddr >= BASE && rdRel < SPAN) begin
      rdData = memQ[rdRel[IDX_W-1:0]];
    end
  end

  assign stat.inRange     = (ptrQ >= BASE) && (relPtr < SPAN);
  assign stat.ctrlPage    = (pageIdx == '0);
  assign stat.latchTarget = (pageIdx == '0) && (startOffQ == OFF_W'(LATCH_OFFSET));
  assign stat.byteCnt     = cntQ;
  assign stat.weLatch     = latchQ;
  assign ptrOut           = ptrQ;

endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwc_pkg::*;
#(
  parameter int WRITE_CYCLES = 20,
  parameter int PAGE_BYTES   = 16,
  parameter int NUM_PAGES    = 5,
  parameter int BASE_ADDR    = 'h80,
  parameter int LATCH_OFFSET = 6,
  parameter int LATCH_BIT    = 7
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic       stopAligned,
  input  logic       addrValid,
  input  logic [7:0] addrByte,
  input  logic       dataValid,
  input  logic [7:0] dataByte,
  input  logic       wpN,
  input  logic [7:0] rdAddr,
  output logic       busy,
  output logic [7:0] ptrOut,
  output logic [7:0] rdData
);

  pwcStrobe_t strb;
  pwcStatus_t stat;

  pwc_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .stopAligned(stopAligned), .addrValid(addrValid), .dataValid(dataValid),
    .wpN(wpN), .stat(stat), .strb(strb), .busy(busy)
  );

  pwc_datapath #(
    .ADDR_W(8), .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES),
    .BASE_ADDR(BASE_ADDR), .LATCH_OFFSET(LATCH_OFFSET), .LATCH_BIT(LATCH_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .addrByte(addrByte), .dataByte(dataByte),
    .strb(strb), .rdAddr(rdAddr), .stat(stat), .ptrOut(ptrOut), .rdData(rdData)
  );

endmodule

// File: rtl/page_write_ctrl_chk.sv
module page_write_ctrl_chk
  import pwc_pkg::*;
#(
  parameter int WRITE_CYCLES = 20
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       wpN,
  input logic [7:0] ptrOut,
  input pwcStrobe_t strb,
  input pwcStatus_t stat
);

  int unsigned busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.storeByte |=> (ptrOut[7:4] == $past(ptrOut[7:4])) && (ptrOut[3:0] == $past(ptrOut[3:0]) + 4'd1)); // R2

  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(strb.commit)); // R6

  AST_BUSY_DEAF: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.loadAddr || strb.storeByte || strb.commit || strb.setLatch)); // R6

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyRun == WRITE_CYCLES); // R6

  AST_COMMIT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> stat.weLatch && wpN); // R8

  AST_CTRL_PAGE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit && stat.ctrlPage) |-> stat.byteCnt == 2'd1); // R7

  AST_IN_RANGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commit || strb.setLatch) |-> stat.inRange); // R12

  AST_LATCH_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLatch |-> stat.latchTarget && stat.byteCnt == 2'd1 && !strb.commit); // R13

  AST_COMMIT_DROPS_BUF: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> strb.clearBuf); // R5

endmodule

bind page_write_ctrl page_write_ctrl_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .wpN(wpN), .ptrOut(ptrOut),
  .strb(strb), .stat(stat)
);

// File: tb/page_write_ctrl_bench.sv
module page_write_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WCYC       = 20;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startEv = 0, stopEv = 0, stopAligned = 1, addrValid = 0, dataValid = 0;
  logic [7:0] addrByte = 0, dataByte = 0, rdAddr = 0;
  logic       wpN = 1;
  logic       busy;
  logic [7:0] ptrOut, rdData;

  page_write_ctrl #(.WRITE_CYCLES(WCYC)) u_page_write_ctrl (
    .clk(clk), .rstN(rstN), .startEv(startEv), .stopEv(stopEv),
    .stopAligned(stopAligned), .addrValid(addrValid), .addrByte(addrByte),
    .dataValid(dataValid), .dataByte(dataByte), .wpN(wpN), .rdAddr(rdAddr),
    .busy(busy), .ptrOut(ptrOut), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int mMem[80];
  int mBuf[16];
  bit mHas[16];
  int mPtr, mStart, mCount, mBusyLeft, mPhase; // phase 0 idle, 1 loading
  bit mLatch;

  task automatic mReset();
    foreach (mMem[i]) mMem[i] = 0;
    foreach (mHas[i]) begin mHas[i] = 0; mBuf[i] = 0; end
    mPtr = 0; mStart = 0; mCount = 0; mBusyLeft = 0; mPhase = 0; mLatch = 0;
  endtask

  task automatic mDrop();
    foreach (mHas[i]) mHas[i] = 0;
    mCount = 0;
  endtask

  task automatic mStop();
    bit ok;
    int pg;
    ok = stopAligned && mPtr >= 'h80 && mPtr <= 'hCF && mCount > 0;
    pg = (mPtr - 'h80) / 16;
    if (ok && mStart == 'h86 && mCount == 1) begin
      mLatch = (mBuf[6] >= 128);
    end else if (ok && mLatch && wpN && (pg != 0 || mCount == 1)) begin
      for (int i = 0; i < 16; i++) if (mHas[i]) mMem[pg*16 + i] = mBuf[i];
      mBusyLeft = WCYC;
    end
    mDrop();
    mPhase = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) mReset();
    else if (mBusyLeft > 0) mBusyLeft--;
    else if (mPhase == 0) begin
      if (addrValid) begin mPtr = addrByte; mStart = addrByte; mDrop(); mPhase = 1; end
    end else begin
      if (startEv) begin mDrop(); mPhase = 0; end
      else if (stopEv) mStop();
      else if (addrValid) begin mPtr = addrByte; mStart = addrByte; mDrop(); end
      else if (dataValid) begin
        mBuf[mPtr % 16] = dataByte;
        mHas[mPtr % 16] = 1;
        mCount++;
        mPtr = (mPtr / 16) * 16 + ((mPtr + 1) % 16);
      end
    end
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busy === (mBusyLeft > 0), "R6 busy", busy, mBusyLeft > 0);
      chk(ptrOut === mPtr[7:0], "R2 pointer", ptrOut, mPtr);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic sendWrite(input logic [7:0] addr, input int n, input logic [7:0] seed,
                           input bit aligned, input bit withStop);
    @(negedge clk) startEv = 1;
    @(negedge clk) startEv = 0; addrValid = 1; addrByte = addr;
    @(negedge clk) addrValid = 0;
    for (int i = 0; i < n; i++) begin
      dataValid = 1; dataByte = seed + 8'(i * 13);
      @(negedge clk);
    end
    dataValid = 0;
    if (withStop) begin
      stopEv = 1; stopAligned = aligned;
      @(negedge clk) stopEv = 0; stopAligned = 1;
    end
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readAt(input logic [7:0] a, output logic [7:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] d;
    int e;
    for (int a = 'h80; a <= 'hCF; a++) begin
      readAt(8'(a), d);
      e = (a == 'h86) ? (mLatch ? 'h80 : 0) : mMem[a - 'h80];
      chk(d === 8'(e), tag, d, e);
    end
    readAt(8'h40, d);
    chk(d === 8'h00, tag, d, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", busy, 0);
    chk(ptrOut === 8'h00, "R1 pointer after reset", ptrOut, 0);
    sweep("R1 reset contents");

    // R8: latch clear, write dropped
    sendWrite(8'hB0, 3, 8'h21, 1, 1); waitIdle();
    readAt(8'hB0, d); chk(d === 8'h00, "R8 write without latch", d, 0);

    // R13: set latch via 86h
    sendWrite(8'h86, 1, 8'h80, 1, 1);
    @(negedge clk); chk(busy === 1'b0, "R13 no write cycle", busy, 0);
    readAt(8'h86, d); chk(d === 8'h80, "R13 latch readback", d, 8'h80);

    // R3: 12 bytes from 9Bh
    sendWrite(8'h9B, 12, 8'h10, 1, 1);
    chk(ptrOut === 8'h97, "R3 pointer ends", ptrOut, 8'h97);
    waitIdle();
    readAt(8'h90, d); chk(d === 8'h10 + 8'(5*13), "R3 wrapped first", d, 8'h10 + 5*13);
    readAt(8'h9B, d); chk(d === 8'h10, "R3 first byte", d, 8'h10);
    readAt(8'h97, d); chk(d === 8'h00, "R3 untouched", d, 0);
    sweep("R3 contents");

    // R4 + R6: 20 bytes to A0h, then a write arriving during busy
    sendWrite(8'hA0, 20, 8'h33, 1, 1);
    sendWrite(8'hC0, 2, 8'h77, 1, 1);
    waitIdle();
    readAt(8'hA0, d); chk(d === 8'h33 + 8'(16*13), "R4 overwrite", d, 8'h33 + 16*13);
    readAt(8'hA4, d); chk(d === 8'h33 + 8'(4*13), "R4 single pass", d, 8'h33 + 4*13);
    readAt(8'hC0, d); chk(d === 8'h00, "R6 ignored while busy", d, 0);
    sweep("R4 R6 contents");

    // R5: partial update, R2 wrap at top page
    sendWrite(8'hCE, 4, 8'h5A, 1, 1); waitIdle();
    sendWrite(8'hA5, 2, 8'hE1, 1, 1); waitIdle();
    sweep("R5 partial commit");

    // R7: control page
    sendWrite(8'h82, 2, 8'h44, 1, 1); waitIdle();
    readAt(8'h82, d); chk(d === 8'h00, "R7 multi-byte control", d, 0);
    sendWrite(8'h83, 1, 8'h45, 1, 1); waitIdle();
    readAt(8'h83, d); chk(d === 8'h45, "R7 single control", d, 8'h45);

    // R10: misaligned stop
    sendWrite(8'hB8, 2, 8'h99, 0, 1); waitIdle();
    readAt(8'hB8, d); chk(d === 8'h00, "R10 misaligned stop", d, 0);

    // R11: START before STOP discards
    sendWrite(8'hBA, 3, 8'h66, 1, 0);
    @(negedge clk) startEv = 1; @(negedge clk) startEv = 0;
    @(negedge clk) stopEv = 1; @(negedge clk) stopEv = 0;
    waitIdle();
    readAt(8'hBA, d); chk(d === 8'h00, "R11 discarded", d, 0);

    // R12: out-of-range addresses
    sendWrite(8'h46, 1, 8'h00, 1, 1); waitIdle();
    sendWrite(8'hD6, 1, 8'h00, 1, 1); waitIdle();
    readAt(8'h86, d); chk(d === 8'h80, "R12 latch intact", d, 8'h80);
    sweep("R12 contents");

    // R9: protect pin
    wpN = 0;
    sendWrite(8'hB1, 2, 8'h12, 1, 1); waitIdle();
    readAt(8'hB1, d); chk(d === 8'h00, "R9 protected write", d, 0);
    sendWrite(8'h86, 1, 8'h00, 1, 1); waitIdle();
    readAt(8'h86, d); chk(d === 8'h00, "R9 latch write under protect", d, 0);
    wpN = 1;
    sendWrite(8'hB1, 2, 8'h12, 1, 1); waitIdle();
    readAt(8'hB1, d); chk(d === 8'h00, "R8 latch cleared blocks", d, 0);
    sendWrite(8'h86, 1, 8'hFF, 1, 1); waitIdle();
    sendWrite(8'hB1, 2, 8'h12, 1, 1); waitIdle();
    readAt(8'hB1, d); chk(d === 8'h12, "R9 write after release", d, 8'h12);
    sweep("R9 contents");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule